// File: doc/BRIEF.md
# Accelerator Control and Interrupt Registers

This block is a memory-mapped register slave on an AXI4-Lite port that steers a streaming processing engine, for example a video field-to-frame converter. Software launches the engine by setting a launch bit; the block holds the launch request toward the engine until the engine takes it with its ready pulse. The block records completion in a sticky bit that clears when software reads it. A self-relaunch mode issues the next launch on its own as soon as the engine reports completion, so runs follow one another with no software turn-around.

Completion and acceptance events also set two interrupt status bits. Each status bit has its own enable, and a master enable gates the single interrupt line. Software clears a status bit by writing a 1 to it, which toggles it. The block also holds four run parameters for the engine: two 32-bit buffer base addresses and two 8-bit mode selectors, all written with byte strobes.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset every register reads 0, `core_start` and `irq` are 0, and no AXI response is pending.
- R2: Writing the control word (offset 0x00) with bit 0 = 1 raises `core_start` on the next cycle. It stays high until a cycle in which `core_ready` is 1, and it is low in the cycle after that. Writing 0 to bit 0 does not withdraw a pending launch.
- R3: Bit 7 of the control word enables self-relaunch. While it is set, a cycle with `core_done` = 1 makes `core_start` 1 in the next cycle. This relaunch wins over an acceptance by `core_ready` in the same cycle. Writing 0 to bit 7 stops further relaunches.
- R4: Control bit 1 is set by `core_done` and stays set until a read of offset 0x00 is accepted. That read returns 1 and clears the bit, unless `core_done` is also high in that same cycle.
- R5: Control bits 2 and 3 return the levels of `core_idle` and `core_ready` in the cycle the read is accepted. They are not latched.
- R6: Offset 0x04 bit 0 is the master interrupt enable. Offset 0x08 bits [1:0] are the per-event enables, with bit 0 for completion and bit 1 for acceptance. Both are read/write.
- R7: Offset 0x0C holds the status bits in the same layout. A status bit is set by a rising edge of `core_done` (bit 0) or `core_ready` (bit 1), not by a level that is held high.
- R8: Writing a 1 to a status bit toggles it, and writing a 0 leaves it unchanged. A rising edge in the same cycle wins and leaves the bit set.
- R9: `irq` equals the master enable ANDed with the OR over both events of (enable AND status).
- R10: Offsets 0x10 and 0x18 hold 32-bit read and write buffer addresses. Offsets 0x20 and 0x28 hold an 8-bit color format and an 8-bit algorithm select. Each byte lane is written only when its strobe is set. Each register drives its output port.
- R11: Reserved bits and unmapped offsets (for example 0x14, 0x1C and 0x3C) read as 0, and writes to them have no effect.
- R12: Every write and read completes with an OKAY (0) response. A response stays valid, with stable read data, until the master accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | Launch request to the engine |
| core_done | input | 1 | Engine completion |
| core_idle | input | 1 | Engine idle level |
| core_ready | input | 1 | Engine accepts a launch |
| rd_fb_addr | output | 32 | Read buffer base address |
| wr_fb_addr | output | 32 | Write buffer base address |
| color_fmt | output | 8 | Color format selector |
| algo_sel | output | 8 | Algorithm selector |
| irq | output | 1 | Interrupt line |

## Verification
The bound checker watches the launch request on every cycle. It checks that the request holds until the acceptance, drops after an acceptance that no relaunch or write opposes, and returns after a completion while self-relaunch is on. It also checks that the completion bit is sticky until a control read, that a completion edge sets its status bit, that the interrupt never rises without a status bit, and that AXI responses stay stable. The clear-on-read of the completion bit, the toggle semantics of the status register, the byte-lane writes, the zero reads of reserved space and the live idle and ready bits can only be shown by the bench's scenarios. The bench compares them against its cycle model.

// File: rtl/acr_pkg.sv
package acr_pkg;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    // word indices (byte offset / 4)
    localparam int WORD_CTRL = 0;
    localparam int WORD_GIE  = 1;
    localparam int WORD_IER  = 2;
    localparam int WORD_ISR  = 3;

    // control word bit positions
    localparam int BIT_START = 0;
    localparam int BIT_DONE  = 1;
    localparam int BIT_IDLE  = 2;
    localparam int BIT_READY = 3;
    localparam int BIT_AUTO  = 7;

    localparam int NUM_PARAMS = 4;
    localparam int NARROW_W   = 8;

    function automatic int param_word(input int i);
        case (i)
            0:       return 4;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    function automatic int param_width(input int i);
        return (i < 2) ? DATA_W : NARROW_W;
    endfunction

    function automatic logic [DATA_W-1:0] field_mask(input int i);
        if (param_width(i) >= DATA_W) return '1;
        return (DATA_W'(1) << param_width(i)) - DATA_W'(1);
    endfunction

    typedef struct packed {
        logic       start;
        logic       done;
        logic       auto_rs;
        logic       gie;
        logic [1:0] ier;
        logic [1:0] isr;
        logic       done_prev;
        logic       ready_prev;
    } ctrl_state_t;
endpackage

// File: rtl/acr_axil_port.sv
module acr_axil_port
    import acr_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int IDX_W = ADDR_W - 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              wr_fire,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb,
    output logic              rd_fire,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_word
);
    typedef struct packed {
        logic              bvalid;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    port_state_t ps_d, ps_q;
    logic        unused_addr_bits;

    assign unused_addr_bits = ^{s_awaddr[1:0], s_araddr[1:0]};

    // a write needs address and data together and a free response slot
    assign wr_fire   = s_awvalid && s_wvalid && !ps_q.bvalid;
    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign wr_idx    = s_awaddr[ADDR_W-1:2];
    assign wr_data   = s_wdata;
    assign wr_strb   = s_wstrb;

    assign s_arready = !ps_q.rvalid;
    assign rd_fire   = s_arvalid && !ps_q.rvalid;
    assign rd_idx    = s_araddr[ADDR_W-1:2];

    always_comb begin
        ps_d = ps_q;
        if (wr_fire)       ps_d.bvalid = 1'b1;
        else if (s_bready) ps_d.bvalid = 1'b0;
        if (rd_fire) begin
            ps_d.rvalid = 1'b1;
            ps_d.rdata  = rd_word;
        end else if (s_rready) begin
            ps_d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign s_bvalid = ps_q.bvalid;
    assign s_rvalid = ps_q.rvalid;
    assign s_rdata  = ps_q.rdata;
endmodule

// File: rtl/acr_ctrl.sv
module acr_ctrl
    import acr_pkg::*;
#(
    parameter int IDX_W = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic             wr_lane0,
    input  logic             rd_ctrl,
    input  logic             core_done,
    input  logic             core_ready,
    output logic             start_o,
    output logic             done_o,
    output logic             auto_o,
    output logic             gie_o,
    output logic [1:0]       ier_o,
    output logic [1:0]       isr_o,
    output logic             irq_o
);
    ctrl_state_t st_d, st_q;
    logic        lane0_wr;
    logic [1:0]  isr_flip;
    logic [1:0]  isr_rise;
    logic        unused_wr_bits;

    assign unused_wr_bits = ^wr_byte[6:2];

    always_comb begin
        st_d     = st_q;
        lane0_wr = wr_fire && wr_lane0;
        isr_flip = 2'b00;
        isr_rise = {core_ready & ~st_q.ready_prev, core_done & ~st_q.done_prev};

        st_d.done_prev  = core_done;
        st_d.ready_prev = core_ready;

        // launch: acceptance clears, software or relaunch sets (set wins)
        if (st_q.start && core_ready) st_d.start = 1'b0;
        if (lane0_wr && wr_idx == IDX_W'(WORD_CTRL)) begin
            if (wr_byte[BIT_START]) st_d.start = 1'b1;
            st_d.auto_rs = wr_byte[BIT_AUTO];
        end
        if (st_q.auto_rs && core_done) st_d.start = 1'b1;

        // completion: sticky, cleared by a control read, new event wins
        if (rd_ctrl)   st_d.done = 1'b0;
        if (core_done) st_d.done = 1'b1;

        if (lane0_wr && wr_idx == IDX_W'(WORD_GIE)) st_d.gie = wr_byte[0];
        if (lane0_wr && wr_idx == IDX_W'(WORD_IER)) st_d.ier = wr_byte[1:0];
        if (lane0_wr && wr_idx == IDX_W'(WORD_ISR)) isr_flip = wr_byte[1:0];
        st_d.isr = (st_q.isr ^ isr_flip) | isr_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o = st_q.start;
    assign done_o  = st_q.done;
    assign auto_o  = st_q.auto_rs;
    assign gie_o   = st_q.gie;
    assign ier_o   = st_q.ier;
    assign isr_o   = st_q.isr;
    assign irq_o   = st_q.gie & |(st_q.ier & st_q.isr);
endmodule

// File: rtl/acr_params.sv
module acr_params
    import acr_pkg::*;
#(
    parameter int IDX_W = 4
)(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_fire,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic [STRB_W-1:0]                   wr_strb,
    output logic [NUM_PARAMS-1:0][DATA_W-1:0]   field_o
);
    for (genvar gi = 0; gi < NUM_PARAMS; gi++) begin : g_field
        localparam logic [DATA_W-1:0] MASK = field_mask(gi);
        localparam logic [IDX_W-1:0]  WORD = IDX_W'(param_word(gi));

        logic [DATA_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_fire && wr_idx == WORD) begin
                for (int b = 0; b < STRB_W; b++) begin
                    if (wr_strb[b]) val_d[8*b +: 8] = wr_data[8*b +: 8];
                end
            end
            val_d = val_d & MASK;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign field_o[gi] = val_q;
    end
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
    import acr_pkg::*;
#(
    parameter int ADDR_W = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              core_start,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    output logic [31:0]       rd_fb_addr,
    output logic [31:0]       wr_fb_addr,
    output logic [7:0]        color_fmt,
    output logic [7:0]        algo_sel,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic                              wr_fire, rd_fire, rd_ctrl;
    logic [IDX_W-1:0]                  wr_idx, rd_idx;
    logic [DATA_W-1:0]                 wr_data, rd_word;
    logic [STRB_W-1:0]                 wr_strb;
    logic                              done_bit, auto_on, gie_bit;
    logic [1:0]                        ier_bits, isr_bits;
    logic [NUM_PARAMS-1:0][DATA_W-1:0] fields;

    acr_axil_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_fire(rd_fire), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    assign rd_ctrl = rd_fire && rd_idx == IDX_W'(WORD_CTRL);

    acr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_byte(wr_data[7:0]), .wr_lane0(wr_strb[0]),
        .rd_ctrl(rd_ctrl), .core_done(core_done), .core_ready(core_ready),
        .start_o(core_start), .done_o(done_bit), .auto_o(auto_on), .gie_o(gie_bit),
        .ier_o(ier_bits), .isr_o(isr_bits), .irq_o(irq)
    );

    acr_params #(.IDX_W(IDX_W)) u_params (
        .clk(clk), .rst_n(rst_n),
        .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
        .field_o(fields)
    );

    always_comb begin
        rd_word = '0;
        if (rd_idx == IDX_W'(WORD_CTRL)) begin
            rd_word[BIT_START] = core_start;
            rd_word[BIT_DONE]  = done_bit;
            rd_word[BIT_IDLE]  = core_idle;
            rd_word[BIT_READY] = core_ready;
            rd_word[BIT_AUTO]  = auto_on;
        end
        if (rd_idx == IDX_W'(WORD_GIE)) rd_word[0]   = gie_bit;
        if (rd_idx == IDX_W'(WORD_IER)) rd_word[1:0] = ier_bits;
        if (rd_idx == IDX_W'(WORD_ISR)) rd_word[1:0] = isr_bits;
        for (int i = 0; i < NUM_PARAMS; i++) begin
            if (rd_idx == IDX_W'(param_word(i))) rd_word = fields[i];
        end
    end

    assign s_bresp    = 2'b00;
    assign s_rresp    = 2'b00;
    assign rd_fb_addr = fields[0];
    assign wr_fb_addr = fields[1];
    assign color_fmt  = fields[2][NARROW_W-1:0];
    assign algo_sel   = fields[3][NARROW_W-1:0];
endmodule

// File: rtl/acr_checker.sv
module acr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        core_start,
    input logic        core_ready,
    input logic        core_done,
    input logic        irq,
    input logic        wr_fire,
    input logic        auto_on,
    input logic        done_bit,
    input logic        rd_ctrl,
    input logic [1:0]  isr_bits,
    input logic        s_bvalid,
    input logic        s_bready,
    input logic        s_rvalid,
    input logic        s_rready,
    input logic [31:0] s_rdata
);
    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        core_start && !core_ready |=> core_start); // R2
    AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        core_start && core_ready && !core_done && !wr_fire |=> !core_start); // R2
    AST_AUTO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        auto_on && core_done |=> core_start); // R3
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_bit && !rd_ctrl |=> done_bit); // R4
    AST_STATUS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_done) |=> isr_bits[0]); // R7
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> isr_bits != 2'b00); // R9
    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid); // R12
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R12
endmodule

bind accel_ctrl_regs acr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_ready(core_ready),
    .core_done(core_done), .irq(irq), .wr_fire(wr_fire), .auto_on(auto_on),
    .done_bit(done_bit), .rd_ctrl(rd_ctrl), .isr_bits(isr_bits),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_rvalid(s_rvalid),
    .s_rready(s_rready), .s_rdata(s_rdata)
);

// File: tb/accel_ctrl_regs_tb.sv
module accel_ctrl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  s_awaddr = '0, s_araddr = '0;
    logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic        s_bready = 1'b1, s_rready = 1'b1;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        core_done = 1'b0, core_idle = 1'b0, core_ready = 1'b0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata, rd_fb_addr, wr_fb_addr;
    logic [7:0]  color_fmt, algo_sel;
    logic        core_start, irq;

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    accel_ctrl_regs u_dut (.*);

    // ---------------- reference model ----------------
    logic        m_start = 0, m_done = 0, m_auto = 0, m_gie = 0, m_pd = 0, m_pr = 0;
    logic [1:0]  m_ier = 0, m_isr = 0;
    logic [31:0] m_par [4] = '{default: 0};
    logic [31:0] m_rexp = 0;
    int          pword [4] = '{4, 6, 8, 10};
    bit          ev_wr = 0, ev_rd = 0;
    int          ev_widx = 0, ev_ridx = 0;
    logic [31:0] ev_wdata = 0;
    logic [3:0]  ev_wstrb = 0;

    function automatic logic [31:0] model_word(input int idx);
        logic [31:0] w = 0;
        case (idx)
            0: w = {24'd0, m_auto, 3'd0, core_ready, core_idle, m_done, m_start};
            1: w = {31'd0, m_gie};
            2: w = {30'd0, m_ier};
            3: w = {30'd0, m_isr};
            default: w = 0;
        endcase
        for (int i = 0; i < 4; i++) if (idx == pword[i]) w = m_par[i];
        return w;
    endfunction

    always @(posedge clk) begin : model
        logic       ns;
        logic [1:0] flip;
        if (!rst_n) begin
            m_start = 0; m_done = 0; m_auto = 0; m_gie = 0; m_pd = 0; m_pr = 0;
            m_ier = 0; m_isr = 0;
            for (int i = 0; i < 4; i++) m_par[i] = 0;
        end else begin
            if (ev_rd) m_rexp = model_word(ev_ridx);
            ns = m_start;
            if (m_start && core_ready) ns = 0;
            flip = 0;
            if (ev_wr && ev_wstrb[0]) begin
                if (ev_widx == 0) begin
                    if (ev_wdata[0]) ns = 1;
                end
                if (ev_widx == 1) m_gie = ev_wdata[0];
                if (ev_widx == 2) m_ier = ev_wdata[1:0];
                if (ev_widx == 3) flip = ev_wdata[1:0];
            end
            if (m_auto && core_done) ns = 1;
            if (ev_wr && ev_wstrb[0] && ev_widx == 0) m_auto = ev_wdata[7];
            m_start = ns;
            if (ev_rd && ev_ridx == 0) m_done = 0;
            if (core_done) m_done = 1;
            m_isr = (m_isr ^ flip) | {core_ready & ~m_pr, core_done & ~m_pd};
            m_pd = core_done; m_pr = core_ready;
            if (ev_wr) begin
                for (int i = 0; i < 4; i++) begin
                    if (ev_widx == pword[i]) begin
                        for (int b = 0; b < 4; b++)
                            if (ev_wstrb[b]) m_par[i][8*b +: 8] = ev_wdata[8*b +: 8];
                        if (i >= 2) m_par[i] = m_par[i] & 32'hFF;
                    end
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2", "core_start vs model", {31'd0, core_start}, {31'd0, m_start});
            chk("R9", "irq vs model", {31'd0, irq}, {31'd0, m_gie & |(m_ier & m_isr)});
            chk("R10", "rd_fb_addr", rd_fb_addr, m_par[0]);
            chk("R10", "wr_fb_addr", wr_fb_addr, m_par[1]);
            chk("R10", "color_fmt", {24'd0, color_fmt}, m_par[2]);
            chk("R10", "algo_sel", {24'd0, algo_sel}, m_par[3]);
        end
    end

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            n_fail++;
            $display("FAIL R12 watchdog: actual=%0d cycles expected=under 20000", cyc);
            summary();
        end
    end

    // ---------------- bus tasks ----------------
    task automatic axi_write(input logic [5:0] addr, input logic [31:0] data, input logic [3:0] strb);
        @(negedge clk);
        s_awaddr = addr; s_awvalid = 1; s_wdata = data; s_wstrb = strb; s_wvalid = 1;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        ev_wr = 1; ev_widx = addr >> 2; ev_wdata = data; ev_wstrb = strb;
        @(posedge clk); #1;
        ev_wr = 0;
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0;
        while (!s_bvalid) @(negedge clk);
        chk("R12", "bresp", {30'd0, s_bresp}, 32'd0);
    endtask

    task automatic axi_read(input logic [5:0] addr, input string tag, output logic [31:0] data);
        @(negedge clk);
        s_araddr = addr; s_arvalid = 1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        ev_rd = 1; ev_ridx = addr >> 2;
        @(posedge clk); #1;
        ev_rd = 0;
        @(negedge clk);
        s_arvalid = 0;
        while (!s_rvalid) @(negedge clk);
        data = s_rdata;
        chk(tag, $sformatf("read 0x%02h", addr), s_rdata, m_rexp);
        chk("R12", "rresp", {30'd0, s_rresp}, 32'd0);
    endtask

    task automatic pulse_done();
        @(negedge clk); core_done = 1; @(negedge clk); core_done = 0;
    endtask
    task automatic pulse_ready();
        @(negedge clk); core_ready = 1; @(negedge clk); core_ready = 0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "core_start after reset", {31'd0, core_start}, 32'd0);
        chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
        chk("R1", "no response pending", {30'd0, s_bvalid, s_rvalid}, 32'd0);
        for (int a = 0; a < 64; a += 4) begin
            axi_read(6'(a), "R1", d);
            chk("R1", "reset read is zero", d, 32'd0);
        end

        // parameters with byte strobes
        axi_write(6'h10, 32'hDEADBEEF, 4'hF);
        axi_write(6'h18, 32'h11223344, 4'b0101);
        axi_write(6'h20, 32'hABCD1234, 4'hF);
        axi_write(6'h28, 32'h000000A5, 4'b0001);
        axi_write(6'h28, 32'h00000077, 4'b0010);
        axi_read(6'h10, "R10", d); chk("R10", "rdfb", d, 32'hDEADBEEF);
        axi_read(6'h18, "R10", d); chk("R10", "wrfb partial lanes", d, 32'h00220044);
        axi_read(6'h20, "R10", d); chk("R10", "color masked", d, 32'h34);
        axi_read(6'h28, "R10", d); chk("R10", "algo lane1 ignored", d, 32'hA5);

        // reserved space
        axi_write(6'h14, 32'hFFFFFFFF, 4'hF);
        axi_write(6'h3C, 32'hFFFFFFFF, 4'hF);
        axi_write(6'h04, 32'hFFFFFFFE, 4'hF);
        axi_read(6'h14, "R11", d); chk("R11", "gap 0x14", d, 0);
        axi_read(6'h3C, "R11", d); chk("R11", "gap 0x3C", d, 0);
        axi_read(6'h04, "R11", d); chk("R11", "gie reserved bits", d, 0);
        axi_read(6'h10, "R11", d); chk("R11", "rdfb untouched", d, 32'hDEADBEEF);

        // launch and acceptance
        axi_write(6'h00, 32'h1, 4'h1);
        repeat (3) @(negedge clk);
        chk("R2", "start held", {31'd0, core_start}, 1);
        axi_write(6'h00, 32'h0, 4'h1);
        chk("R2", "zero write keeps start", {31'd0, core_start}, 1);
        pulse_ready();
        chk("R2", "start cleared by ready", {31'd0, core_start}, 0);

        // completion bit
        @(negedge clk); core_done = 1;
        axi_read(6'h00, "R4", d);
        @(negedge clk); core_done = 0;
        axi_read(6'h00, "R4", d); chk("R4", "done sticky across read", {31'd0, d[1]}, 1);
        axi_read(6'h00, "R4", d); chk("R4", "done cleared by read", {31'd0, d[1]}, 0);

        // live idle/ready
        @(negedge clk); core_idle = 1; core_ready = 1;
        axi_read(6'h00, "R5", d); chk("R5", "idle+ready bits", d & 32'hC, 32'hC);
        @(negedge clk); core_idle = 0; core_ready = 0;
        axi_read(6'h00, "R5", d); chk("R5", "idle+ready low", d & 32'hC, 0);

        // self-relaunch
        axi_write(6'h00, 32'h80, 4'h1);
        axi_write(6'h00, 32'h81, 4'h1);
        pulse_ready();
        chk("R3", "accepted", {31'd0, core_start}, 0);
        pulse_done();
        chk("R3", "relaunch after done", {31'd0, core_start}, 1);
        @(negedge clk); core_done = 1; core_ready = 1;
        @(negedge clk); core_done = 0; core_ready = 0;
        chk("R3", "relaunch beats acceptance", {31'd0, core_start}, 1);
        axi_write(6'h00, 32'h0, 4'h1);
        pulse_ready();
        pulse_done();
        @(negedge clk);
        chk("R3", "no relaunch after disable", {31'd0, core_start}, 0);

        // interrupt enables and status
        axi_write(6'h08, 32'h3, 4'h1);
        axi_read(6'h08, "R6", d); chk("R6", "ier", d, 3);
        axi_write(6'h04, 32'h1, 4'h1);
        axi_read(6'h04, "R6", d); chk("R6", "gie", d, 1);
        axi_read(6'h0C, "R7", d); chk("R7", "status after events", d, 3);
        chk("R9", "irq high", {31'd0, irq}, 1);
        axi_write(6'h0C, 32'h3, 4'h1);
        axi_read(6'h0C, "R8", d); chk("R8", "toggle clears", d, 0);
        chk("R9", "irq low", {31'd0, irq}, 0);
        @(negedge clk); core_ready = 1;
        repeat (2) @(negedge clk);
        axi_write(6'h0C, 32'h2, 4'h1);
        repeat (3) @(negedge clk);
        axi_read(6'h0C, "R7", d); chk("R7", "held level does not reset bit", d, 0);
        @(negedge clk); core_ready = 0;
        axi_write(6'h0C, 32'h1, 4'h1);
        axi_read(6'h0C, "R8", d); chk("R8", "toggle sets zero bit", d, 1);
        axi_write(6'h0C, 32'h0, 4'h1);
        axi_read(6'h0C, "R8", d); chk("R8", "zero write no effect", d, 1);
        axi_write(6'h08, 32'h2, 4'h1);
        chk("R9", "masked event", {31'd0, irq}, 0);
        axi_write(6'h08, 32'h1, 4'h1);
        chk("R9", "enabled event", {31'd0, irq}, 1);
        axi_write(6'h04, 32'h0, 4'h1);
        chk("R9", "global gate", {31'd0, irq}, 0);

        // slow response acceptance
        @(negedge clk); s_rready = 0;
        axi_read(6'h10, "R12", d);
        repeat (3) @(negedge clk);
        chk("R12", "rdata held", s_rdata, 32'hDEADBEEF);
        chk("R12", "rvalid held", {31'd0, s_rvalid}, 1);
        s_rready = 1;
        repeat (2) @(negedge clk);
        summary();
    end
endmodule